// File: doc/BRIEF.md
# SPI Controller FIFO and Interrupt Unit

This block is the register-side front end of a master-only SPI controller. Software reaches it through a simple 32-bit register port. The block holds a transmit queue and a receive queue of 32-bit words, each eight entries deep. It also holds a global enable, a threshold for each queue, flush controls, a status word and a set of interrupt enable, status and clear registers. It drives one interrupt line.

The serial shift engine is a separate neighbour. It sees the head of the transmit queue through a valid and word pair and pulls words with a take strobe. It returns received words with a push strobe, and it reports through a busy input whether it is still shifting. One address carries both transmit and receive data, so a write queues a transmit word and a read dequeues a received word. In the same way, one address reads as interrupt status and clears status bits when written.

The receive-complete event fires when the receive queue fills up to the programmed receive threshold. The transmit-complete event fires when the transmit queue has drained and the shifter has gone idle.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the enable is 0, both queues are empty, both thresholds and all interrupt enables read 0, all interrupt status bits read 0, and the interrupt output is low.
- R2: Bit 0 of the control register at offset 0x00 is the enable and drives `ctl_en`. While it is 0, `tx_valid` stays low and words pushed by the shifter are discarded, so the receive queue does not change.
- R3: A write to offset 0x24 appends `reg_wdata` to the transmit queue. The queue presents its oldest word on `tx_word` with `tx_valid` high, and each `tx_take` cycle advances to the next word in write order.
- R4: A read of offset 0x24 returns the oldest received word on `reg_rdata` in the same cycle and removes it. A read while the queue is empty returns 0 and leaves the queue unchanged.
- R5: Each queue holds at most 8 words. A transmit write while 8 words are held is dropped.
- R6: The queue control register at offset 0x20 keeps the transmit threshold in bits 11:8 and the receive threshold in bits 3:0. Writing 1 to bit 12 empties the transmit queue and writing 1 to bit 4 empties the receive queue. Bits 12 and 4 always read back as 0.
- R7: Bit 0 of the status register at offset 0x14 reads 1 exactly while the receive queue holds at least one word.
- R8: A shifter push that arrives while the enable is 1 and the receive queue holds 8 words (and no read pops it in that cycle) is dropped and sets the sticky overrun bit, bit 0 at offset 0x1C.
- R9: Receive-ready, bit 9 at offset 0x1C, reads 1 while the receive threshold is non-zero and the receive count is at or above it. Receive-complete, bit 3 at offset 0x1C, is sticky and is set one cycle after receive-ready goes from 0 to 1.
- R10: Transmit-complete, bit 4 at offset 0x1C, is sticky and is set one cycle after the transmit queue is empty with `shifter_busy` low, following a cycle in which the queue held a word or the shifter was busy.
- R11: A write to offset 0x1C clears bit 4, bit 3 and bit 0 wherever the written value has a 1. Bits written as 0 keep their value.
- R12: The interrupt enable register at offset 0x18 holds a receive-complete enable in bit 3 and an overrun enable in bit 0. `irq` is high exactly while an enabled status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of 0x24 pops) |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| ctl_en | output | 1 | Controller enable to the shifter |
| tx_valid | output | 1 | A transmit word is available |
| tx_word | output | 32 | Oldest transmit word |
| tx_take | input | 1 | Shifter consumes the oldest transmit word |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_word | input | 32 | Received word |
| shifter_busy | input | 1 | Shifter is still shifting a word |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches on every cycle that neither queue exceeds eight words, that a disabled controller never grows the receive queue, and that an empty-queue read or a receive flush leaves the receive queue empty. It also checks that receive-complete and overrun only rise after receive-ready or a full queue, that overrun stays set until it is cleared, and that the interrupt line is never high without a status bit behind it. Word ordering through both queues, the dropped ninth word, threshold readback and the exact bit layout of the status words can only be shown by the directed scenarios. The same holds for the timing of the transmit-complete event against the busy input and for the selective effect of clear masks.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

    localparam int unsigned REG_AW = 6;
    localparam int unsigned THR_W  = 4;

    localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 6'h14;
    localparam logic [REG_AW-1:0] OFS_IEN  = 6'h18;
    localparam logic [REG_AW-1:0] OFS_ISR  = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_QCTL = 6'h20;
    localparam logic [REG_AW-1:0] OFS_DATA = 6'h24;

    // bit positions that software and the shifter rely on
    localparam int unsigned B_EN       = 0;
    localparam int unsigned B_IE_OVR   = 0;
    localparam int unsigned B_IE_RC    = 3;
    localparam int unsigned B_ST_OVR   = 0;
    localparam int unsigned B_ST_RC    = 3;
    localparam int unsigned B_ST_TXC   = 4;
    localparam int unsigned B_ST_RDY   = 9;
    localparam int unsigned B_FL_RX    = 4;
    localparam int unsigned B_FL_TX    = 12;
    localparam int unsigned B_RXTHR_LO = 0;
    localparam int unsigned B_TXTHR_LO = 8;

    typedef struct packed {
        logic             en;
        logic             ie_rc;
        logic             ie_ovr;
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
    } cfg_t;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t             st_d, st_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != FULL_CNT) || do_pop);
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                mem_d[st_q.wr_ptr] = push_data;
                st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULL_CNT);
    assign count = st_q.cnt;
    assign head  = empty ? '0 : mem_q[st_q.rd_ptr];

endmodule

// File: rtl/spi_irq_events.sv
module spi_irq_events #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic             shifter_busy,
    input  logic             ovr_evt,
    input  logic             clr_txc,
    input  logic             clr_rc,
    input  logic             clr_ovr,
    output logic             rx_ready,
    output logic             txc,
    output logic             rc,
    output logic             ovr
);

    typedef struct packed {
        logic txc;
        logic rc;
        logic ovr;
        logic tx_act;
        logic rdy;
    } ev_t;

    ev_t  ev_d, ev_q;
    logic rdy_now, act_now;

    always_comb begin
        rdy_now = (rx_thr != '0) && (32'(rx_cnt) >= 32'(rx_thr));
        act_now = (tx_cnt != '0) || shifter_busy;

        ev_d        = ev_q;
        ev_d.rdy    = rdy_now;
        ev_d.tx_act = act_now;
        ev_d.txc    = (ev_q.txc && !clr_txc) || (ev_q.tx_act && !act_now);
        ev_d.rc     = (ev_q.rc  && !clr_rc)  || (rdy_now && !ev_q.rdy);
        ev_d.ovr    = (ev_q.ovr && !clr_ovr) || ovr_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign rx_ready = rdy_now;
    assign txc      = ev_q.txc;
    assign rc       = ev_q.rc;
    assign ovr      = ev_q.ovr;

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fifo_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        ctl_en,
    output logic        tx_valid,
    output logic [31:0] tx_word,
    input  logic        tx_take,
    input  logic        rx_push,
    input  logic [31:0] rx_word,
    input  logic        shifter_busy,
    output logic        irq
);

    cfg_t cfg_d, cfg_q;

    logic             wr_ctrl, wr_ien, wr_isr, wr_qctl, wr_data, rd_data;
    logic             tx_flush, rx_flush, tx_pop, rx_in, ovr_evt;
    logic [31:0]      rx_head;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             rx_ready, txc, rc, ovr;

    // access decode: the direction selects the register behind shared offsets
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
        wr_ien   = reg_wr && (reg_addr == OFS_IEN);
        wr_isr   = reg_wr && (reg_addr == OFS_ISR);
        wr_qctl  = reg_wr && (reg_addr == OFS_QCTL);
        wr_data  = reg_wr && (reg_addr == OFS_DATA);
        rd_data  = reg_rd && (reg_addr == OFS_DATA);
        tx_flush = wr_qctl && reg_wdata[B_FL_TX];
        rx_flush = wr_qctl && reg_wdata[B_FL_RX];
        tx_pop   = cfg_q.en && tx_take;
        rx_in    = cfg_q.en && rx_push;
        ovr_evt  = rx_in && rx_full && !rd_data;
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.en = reg_wdata[B_EN];
        end
        if (wr_ien) begin
            cfg_d.ie_rc  = reg_wdata[B_IE_RC];
            cfg_d.ie_ovr = reg_wdata[B_IE_OVR];
        end
        if (wr_qctl) begin
            cfg_d.tx_thr = reg_wdata[B_TXTHR_LO +: THR_W];
            cfg_d.rx_thr = reg_wdata[B_RXTHR_LO +: THR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    spi_word_fifo #(.WIDTH(32), .DEPTH(DEPTH)) i_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (wr_data),
        .push_data (reg_wdata),
        .pop       (tx_pop),
        .head      (tx_word),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    spi_word_fifo #(.WIDTH(32), .DEPTH(DEPTH)) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_in),
        .push_data (rx_word),
        .pop       (rd_data),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    spi_irq_events #(.CNT_W(CNT_W), .THR_W(THR_W)) i_events (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_cnt       (rx_cnt),
        .rx_thr       (cfg_q.rx_thr),
        .tx_cnt       (tx_cnt),
        .shifter_busy (shifter_busy),
        .ovr_evt      (ovr_evt),
        .clr_txc      (wr_isr && reg_wdata[B_ST_TXC]),
        .clr_rc       (wr_isr && reg_wdata[B_ST_RC]),
        .clr_ovr      (wr_isr && reg_wdata[B_ST_OVR]),
        .rx_ready     (rx_ready),
        .txc          (txc),
        .rc           (rc),
        .ovr          (ovr)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata[B_EN] = cfg_q.en;
            OFS_STAT: reg_rdata[0]    = !rx_empty;
            OFS_IEN: begin
                reg_rdata[B_IE_RC]  = cfg_q.ie_rc;
                reg_rdata[B_IE_OVR] = cfg_q.ie_ovr;
            end
            OFS_ISR: begin
                reg_rdata[B_ST_RDY] = rx_ready;
                reg_rdata[B_ST_TXC] = txc;
                reg_rdata[B_ST_RC]  = rc;
                reg_rdata[B_ST_OVR] = ovr;
            end
            OFS_QCTL: begin
                reg_rdata[B_TXTHR_LO +: THR_W] = cfg_q.tx_thr;
                reg_rdata[B_RXTHR_LO +: THR_W] = cfg_q.rx_thr;
            end
            OFS_DATA: reg_rdata = rx_head;
            default:  reg_rdata = '0;
        endcase
    end

    assign ctl_en   = cfg_q.en;
    assign tx_valid = cfg_q.en && !tx_empty;
    assign irq      = (cfg_q.ie_rc && rc) || (cfg_q.ie_ovr && ovr);

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [5:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             ctl_en,
    input logic             rx_push,
    input logic             irq,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt,
    input logic             rx_ready,
    input logic             rc,
    input logic             ovr
);

    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rx_cnt) <= DEPTH); // R5
    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tx_cnt) <= DEPTH); // R5
    AST_DISABLED_DROPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && rx_push) |=> (rx_cnt <= $past(rx_cnt))); // R2
    AST_EMPTY_POP_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 6'h24 && rx_cnt == '0 && !rx_push) |=> (rx_cnt == '0)); // R4
    AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 6'h20 && reg_wdata[4]) |=> (rx_cnt == '0)); // R6
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> (32'($past(rx_cnt)) == DEPTH)); // R8
    AST_RC_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc) |-> $past(rx_ready)); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(reg_wr && reg_addr == 6'h1C && reg_wdata[0])) |=> ovr); // R11
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rc || ovr)); // R12

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctl_en    (ctl_en),
    .rx_push   (rx_push),
    .irq       (irq),
    .rx_cnt    (rx_cnt),
    .tx_cnt    (tx_cnt),
    .rx_ready  (rx_ready),
    .rc        (rc),
    .ovr       (ovr)
);

// File: tb/test_spi_fifo_irq_unit.sv
module test_spi_fifo_irq_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_en, tx_valid, irq;
    logic [31:0] tx_word;
    logic        tx_take = 1'b0, rx_push = 1'b0, shifter_busy = 1'b0;
    logic [31:0] rx_word = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_fifo_irq_unit i_spi_fifo_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_en(ctl_en), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_take(tx_take), .rx_push(rx_push), .rx_word(rx_word),
        .shifter_busy(shifter_busy), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic sh_push(input logic [31:0] w);
        @(negedge clk);
        rx_push = 1'b1; rx_word = w;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic sh_take();
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        chk_eq("R1 irq", {31'b0, irq}, 32'd0);
        chk_eq("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
        chk_eq("R1 ctl_en", {31'b0, ctl_en}, 32'd0);
        bus_read(6'h00, d); chk_eq("R1 ctrl", d, 32'd0);
        bus_read(6'h14, d); chk_eq("R1 status", d, 32'd0);
        bus_read(6'h18, d); chk_eq("R1 ien", d, 32'd0);
        bus_read(6'h1C, d); chk_eq("R1 isr", d, 32'd0);
        bus_read(6'h20, d); chk_eq("R1 qctl", d, 32'd0);
    endtask

    task automatic t_tx_path();
        logic [31:0] d;
        bus_write(6'h24, 32'h11);
        bus_write(6'h24, 32'h22);
        bus_write(6'h24, 32'h33);
        #1 chk_eq("R2 tx_valid low while disabled", {31'b0, tx_valid}, 32'd0);
        bus_write(6'h00, 32'h1);
        #1;
        chk_eq("R2 ctl_en", {31'b0, ctl_en}, 32'd1);
        chk_eq("R3 tx_valid", {31'b0, tx_valid}, 32'd1);
        chk_eq("R3 first word", tx_word, 32'h11);
        sh_take();
        #1 chk_eq("R3 second word", tx_word, 32'h22);
        bus_write(6'h20, 32'h1000);
        #1 chk_eq("R6 tx flush", {31'b0, tx_valid}, 32'd0);
        idle(2);
        bus_read(6'h1C, d); chk_eq("R10 txc after drain", d & 32'h10, 32'h10);
        bus_write(6'h1C, 32'h10);
        bus_read(6'h1C, d); chk_eq("R11 txc cleared", d, 32'd0);
        shifter_busy = 1'b1;
        for (int i = 0; i < 9; i++) bus_write(6'h24, 32'hA0 + i);
        for (int i = 0; i < 7; i++) sh_take();
        #1 chk_eq("R3 eighth word in order", tx_word, 32'hA7);
        sh_take();
        #1 chk_eq("R5 ninth word dropped", {31'b0, tx_valid}, 32'd0);
        idle(2);
        bus_read(6'h1C, d); chk_eq("R10 no txc while busy", d & 32'h10, 32'd0);
        @(negedge clk) shifter_busy = 1'b0;
        idle(2);
        bus_read(6'h1C, d); chk_eq("R10 txc after idle", d & 32'h10, 32'h10);
        bus_write(6'h1C, 32'h10);
    endtask

    task automatic t_rx_threshold();
        logic [31:0] d;
        bus_write(6'h20, 32'h0003);
        bus_write(6'h18, 32'h8);
        bus_read(6'h18, d); chk_eq("R12 ien readback", d, 32'h8);
        sh_push(32'h101);
        sh_push(32'h102);
        idle(2);
        bus_read(6'h14, d); chk_eq("R7 not empty", d, 32'd1);
        bus_read(6'h1C, d); chk_eq("R9 below threshold", d, 32'd0);
        #1 chk_eq("R12 irq low", {31'b0, irq}, 32'd0);
        sh_push(32'h103);
        idle(2);
        bus_read(6'h1C, d); chk_eq("R9 ready and complete", d, 32'h208);
        #1 chk_eq("R12 irq high", {31'b0, irq}, 32'd1);
        bus_read(6'h24, d); chk_eq("R4 pop 1", d, 32'h101);
        bus_read(6'h24, d); chk_eq("R4 pop 2", d, 32'h102);
        bus_read(6'h24, d); chk_eq("R4 pop 3", d, 32'h103);
        bus_read(6'h1C, d); chk_eq("R9 complete sticky, ready gone", d, 32'h008);
        bus_write(6'h1C, 32'h8);
        #1 chk_eq("R11 irq after clear", {31'b0, irq}, 32'd0);
        bus_read(6'h1C, d); chk_eq("R11 rc cleared", d, 32'd0);
        bus_read(6'h24, d); chk_eq("R4 empty read", d, 32'd0);
        bus_read(6'h14, d); chk_eq("R7 empty", d, 32'd0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        bus_write(6'h18, 32'h1);
        for (int i = 0; i < 9; i++) sh_push(32'h200 + i);
        idle(1);
        bus_read(6'h1C, d); chk_eq("R8 overrun set", d & 32'h1, 32'h1);
        #1 chk_eq("R12 irq on overrun", {31'b0, irq}, 32'd1);
        bus_write(6'h1C, 32'h0);
        bus_read(6'h1C, d); chk_eq("R11 zero write keeps", d & 32'h1, 32'h1);
        for (int i = 0; i < 7; i++) bus_read(6'h24, d);
        bus_read(6'h24, d); chk_eq("R8 last kept word", d, 32'h207);
        bus_read(6'h24, d); chk_eq("R5 ninth rx dropped", d, 32'd0);
        bus_write(6'h1C, 32'h19);
        bus_read(6'h1C, d); chk_eq("R11 overrun cleared", d, 32'd0);
        #1 chk_eq("R12 irq low", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_flush_and_disable();
        logic [31:0] d;
        sh_push(32'h301);
        sh_push(32'h302);
        bus_write(6'h20, 32'h0517);
        bus_read(6'h20, d); chk_eq("R6 thresholds, flush bits read 0", d, 32'h0507);
        bus_read(6'h14, d); chk_eq("R6 rx flushed", d, 32'd0);
        bus_write(6'h00, 32'h0);
        bus_read(6'h00, d); chk_eq("R2 ctrl off", d, 32'd0);
        sh_push(32'h3FF);
        bus_read(6'h14, d); chk_eq("R2 rx ignored while disabled", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_path();
        t_rx_threshold();
        t_overrun();
        t_flush_and_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule